// File: doc/BRIEF.md
# Variable Bit-Field Reduce and Access Unit

This block takes one N-bit data word and, under a three-bit operation code, either folds a runtime-selected run of its bits down to one bit (AND, OR or XOR), pulls that run out right-aligned, reads or rewrites a single bit, or returns the top or bottom bit. The run is given by two runtime indices: an upper bound and a lower bound, both inclusive. A separate bit index addresses the single-bit operations.

All arithmetic is combinational. The result, a one-bit reduction output and a valid flag are captured in one register stage on the rising clock edge when the clock enable is high. Requests whose bounds fall outside the word, or whose upper bound is below the lower one, produce a zero result with valid low. The unit drops into any datapath that needs header-field decode, parity over a sub-range or flag manipulation with bounds known only at run time.

Top module: `bitfield_unit`

## Requirements
- R1: Operation code 0 sets `red` to the AND of word bits `hi_idx` down to `lo_idx` inclusive; `res` holds that bit at position 0 and zeros above.
- R2: Operation code 1 sets `red` to the OR of the same inclusive run; `res` holds it at bit 0.
- R3: Operation code 2 sets `red` to the XOR of the same inclusive run; `res` holds it at bit 0.
- R4: Operation code 3 returns bits `hi_idx` down to `lo_idx` in `res` starting at bit 0, zero above bit `hi_idx - lo_idx`; `red` is 0.
- R5: Operation code 4 returns word bit `bit_idx` in `red` and at `res` bit 0.
- R6: Operation code 5 returns the word with bit `bit_idx` cleared when `set_val` is zero and set for any nonzero `set_val`, all other bits unchanged; `red` is 0.
- R7: Operation code 6 returns the most significant word bit and code 7 the least significant, each in `red` and at `res` bit 0; these are always valid.
- R8: For codes 0 to 3, `hi_idx < lo_idx` or either index at N or above gives `res` = 0, `red` = 0, `vld` = 0; for codes 4 and 5, `bit_idx` at N or above does the same.
- R9: Outputs update one rising edge after inputs are applied with `en` high; with `en` low they hold their values.
- R10: A synchronous `rst` high at a rising edge clears `res`, `red` and `vld` to 0.
- R11: `vld` is 1 for every request not covered by R8, and `red` is never 1 while `vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the output register |
| op | input | 3 | Operation code, 0 to 7 |
| word | input | WIDTH | Data word |
| hi_idx | input | IDX_W | Inclusive upper bound of the field |
| lo_idx | input | IDX_W | Inclusive lower bound of the field |
| bit_idx | input | IDX_W | Bit address for codes 4 and 5 |
| set_val | input | SVAL_W | Value for code 5; zero clears, nonzero sets |
| res | output | WIDTH | Result word |
| red | output | 1 | One-bit reduction or bit-read result |
| vld | output | 1 | Request was legal |

## Verification
The bench builds the unit at its default WIDTH of 16, which gives index ports of 5 bits. At that width every pair of bounds from 0 to 16 can be swept for each field operation against several words, so all legal fields, every reversed pair and the first out-of-range value N are all covered. Index values well above N (up to 31) also become reachable, which exercises the range checks on the upper index bit rather than only the wrap-around of the low bits.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;

    typedef enum logic [2:0] {
        OP_AND_RED = 3'd0,
        OP_OR_RED  = 3'd1,
        OP_XOR_RED = 3'd2,
        OP_EXTRACT = 3'd3,
        OP_GET_BIT = 3'd4,
        OP_PUT_BIT = 3'd5,
        OP_TOP_BIT = 3'd6,
        OP_BOT_BIT = 3'd7
    } bf_op_e;

endpackage

// File: rtl/bitfield_mask.sv
// Builds the field mask from the two bounds by comparing each bit position
// against both of them (two thermometer codes ANDed together).
module bitfield_mask #(
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(WIDTH) + 1
) (
    input  logic [IDX_W-1:0] hi_idx,
    input  logic [IDX_W-1:0] lo_idx,
    output logic [WIDTH-1:0] mask,
    output logic             field_ok
);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(WIDTH);

    logic [WIDTH-1:0] below_hi;
    logic [WIDTH-1:0] above_lo;

    for (genvar i = 0; i < WIDTH; i++) begin : g_therm
        assign below_hi[i] = (IDX_W'(i) <= hi_idx);
        assign above_lo[i] = (IDX_W'(i) >= lo_idx);
    end

    assign mask     = below_hi & above_lo;
    assign field_ok = (hi_idx >= lo_idx) && (hi_idx < LIMIT);
endmodule

// File: rtl/bitfield_reduce.sv
// Folds the masked word three ways and right-aligns the masked field.
module bitfield_reduce #(
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] word,
    input  logic [WIDTH-1:0] mask,
    input  logic [IDX_W-1:0] lo_idx,
    output logic             and_r,
    output logic             or_r,
    output logic             xor_r,
    output logic [WIDTH-1:0] field
);
    logic [WIDTH-1:0] kept;

    assign kept  = word & mask;
    // Bits outside the field are forced high so they cannot pull AND low.
    assign and_r = &(word | ~mask);
    assign or_r  = |kept;
    assign xor_r = ^kept;
    assign field = kept >> lo_idx;
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
    parameter int WIDTH  = 16,
    parameter int SVAL_W = 4,
    parameter int IDX_W  = $clog2(WIDTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [2:0]        op,
    input  logic [WIDTH-1:0]  word,
    input  logic [IDX_W-1:0]  hi_idx,
    input  logic [IDX_W-1:0]  lo_idx,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [SVAL_W-1:0] set_val,
    output logic [WIDTH-1:0]  res,
    output logic              red,
    output logic              vld
);
    import bitfield_pkg::*;

    localparam int               POS_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(WIDTH);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             red;
        logic             vld;
    } out_t;

    out_t st_d, st_q;

    logic [WIDTH-1:0] mask;
    logic             field_ok;
    logic             and_r, or_r, xor_r;
    logic [WIDTH-1:0] field;
    logic             bit_ok;
    logic [POS_W-1:0] pos;
    logic             picked;
    logic [WIDTH-1:0] edited;
    bf_op_e           op_e;

    bitfield_mask #(.WIDTH(WIDTH), .IDX_W(IDX_W)) mask_i (
        .hi_idx   (hi_idx),
        .lo_idx   (lo_idx),
        .mask     (mask),
        .field_ok (field_ok)
    );

    bitfield_reduce #(.WIDTH(WIDTH), .IDX_W(IDX_W)) reduce_i (
        .word   (word),
        .mask   (mask),
        .lo_idx (lo_idx),
        .and_r  (and_r),
        .or_r   (or_r),
        .xor_r  (xor_r),
        .field  (field)
    );

    assign op_e   = bf_op_e'(op);
    assign bit_ok = (bit_idx < LIMIT);
    assign pos    = bit_idx[POS_W-1:0];
    assign picked = word[pos];

    always_comb begin
        edited      = word;
        edited[pos] = |set_val;
    end

    always_comb begin
        st_d = '0;
        unique case (op_e)
            OP_AND_RED: begin st_d.red = and_r; st_d.vld = field_ok; end
            OP_OR_RED:  begin st_d.red = or_r;  st_d.vld = field_ok; end
            OP_XOR_RED: begin st_d.red = xor_r; st_d.vld = field_ok; end
            OP_EXTRACT: begin st_d.res = field; st_d.vld = field_ok; end
            OP_GET_BIT: begin st_d.red = picked; st_d.vld = bit_ok; end
            OP_PUT_BIT: begin st_d.res = edited; st_d.vld = bit_ok; end
            OP_TOP_BIT: begin st_d.red = word[WIDTH-1]; st_d.vld = 1'b1; end
            OP_BOT_BIT: begin st_d.red = word[0]; st_d.vld = 1'b1; end
        endcase
        if (op_e != OP_EXTRACT && op_e != OP_PUT_BIT) begin
            st_d.res = WIDTH'(st_d.red);
        end
        if (!st_d.vld) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (en) begin
            st_q <= st_d;
        end
    end

    assign res = st_q.res;
    assign red = st_q.red;
    assign vld = st_q.vld;

    // R10: reset clears all outputs
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (res == '0) && !red && !vld);

    // R9: with enable low the outputs hold
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(res) && $stable(red) && $stable(vld));

    // R8: reversed bounds on a field operation give zero and invalid
    a_r8_reversed_field: assert property (@(posedge clk) disable iff (rst)
        (en && op <= 3'd3 && hi_idx < lo_idx) |=> (res == '0) && !red && !vld);

    // R8: out-of-range bit address gives zero and invalid
    a_r8_bit_range: assert property (@(posedge clk) disable iff (rst)
        (en && (op == 3'd4 || op == 3'd5) && bit_idx >= LIMIT)
        |=> (res == '0) && !vld);

    // R11: a reduction bit is never reported on an invalid result
    a_r11_red_needs_vld: assert property (@(posedge clk) disable iff (rst)
        red |-> vld);

    // R4: an extracted field has no bits above its width
    a_r4_extract_zero_ext: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'd3 && hi_idx >= lo_idx && hi_idx < LIMIT)
        |=> (((res >> ($past(hi_idx) - $past(lo_idx))) >> 1) == '0) && vld && !red);

    // R7: top-bit code returns the word's MSB
    a_r7_top_bit: assert property (@(posedge clk) disable iff (rst)
        (en && op == 3'd6) |=> vld && (red == $past(word[WIDTH-1])));
endmodule

// File: tb/bitfield_unit_tb_top.sv
module bitfield_unit_tb_top;
    localparam int W  = 16;
    localparam int SV = 4;
    localparam int IW = $clog2(W) + 1;

    logic          clk = 1'b0;
    logic          rst, en;
    logic [2:0]    op;
    logic [W-1:0]  word;
    logic [IW-1:0] hi_idx, lo_idx, bit_idx;
    logic [SV-1:0] set_val;
    logic [W-1:0]  res;
    logic          red, vld;

    int vectors = 0;
    int misses  = 0;

    always #5 clk = ~clk;

    bitfield_unit #(.WIDTH(W), .SVAL_W(SV)) dut_i (
        .clk, .rst, .en, .op, .word, .hi_idx, .lo_idx, .bit_idx, .set_val,
        .res, .red, .vld
    );

    task automatic check(string req, logic [W-1:0] er, logic ered, logic evld);
        vectors++;
        if (res !== er || red !== ered || vld !== evld) begin
            misses++;
            $display("FAIL %s op=%0d hi=%0d lo=%0d bit=%0d: res=%h red=%b vld=%b expected res=%h red=%b vld=%b",
                     req, op, hi_idx, lo_idx, bit_idx, res, red, vld, er, ered, evld);
        end
    endtask

    // Bit-loop reference
    task automatic model(input int o, input logic [W-1:0] w, input int h, input int l,
                         input int b, input int s,
                         output logic [W-1:0] er, output logic ered, output logic evld);
        logic a = 1'b1, r = 1'b0, x = 1'b0;
        logic [W-1:0] f = '0;
        bit fok = (h >= l) && (h < W);
        bit bok = (b < W);
        er = '0; ered = 1'b0; evld = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i <= h && i >= l) begin
                a = a & w[i]; r = r | w[i]; x = x ^ w[i];
                f[i-l] = w[i];
            end
        end
        case (o)
            0: if (fok) begin ered = a; evld = 1; end
            1: if (fok) begin ered = r; evld = 1; end
            2: if (fok) begin ered = x; evld = 1; end
            3: if (fok) begin er = f; evld = 1; end
            4: if (bok) begin ered = w[b]; evld = 1; end
            5: if (bok) begin er = w; er[b] = (s != 0); evld = 1; end
            6: begin ered = w[W-1]; evld = 1; end
            default: begin ered = w[0]; evld = 1; end
        endcase
        if (o != 3 && o != 5) er = W'(ered);
    endtask

    // Drive at a falling edge, sample at the next falling edge.
    task automatic apply(string req, int o, logic [W-1:0] w, int h, int l, int b, int s);
        logic [W-1:0] er; logic ered, evld;
        op = 3'(o); word = w; hi_idx = IW'(h); lo_idx = IW'(l);
        bit_idx = IW'(b); set_val = SV'(s); en = 1'b1;
        model(o, w, h, l, b, s, er, ered, evld);
        @(negedge clk);
        check(req, er, ered, evld);
    endtask

    task automatic t_reset();
        rst = 1'b1; en = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R10", '0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_reductions();
        logic [W-1:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0810};
        for (int p = 0; p < 6; p++) begin
            logic [W-1:0] w = (p < 4) ? pats[p] : W'($urandom);
            for (int h = 0; h <= W; h++)
                for (int l = 0; l <= W; l++) begin
                    apply("R1", 0, w, h, l, 0, 0);
                    apply("R2", 1, w, h, l, 0, 0);
                    apply("R3", 2, w, h, l, 0, 0);
                end
        end
    endtask

    task automatic t_extract();
        for (int p = 0; p < 4; p++) begin
            logic [W-1:0] w = (p == 0) ? 16'hFFFF : W'($urandom);
            for (int h = 0; h <= W; h++)
                for (int l = 0; l <= W; l++)
                    apply("R4", 3, w, h, l, 0, 0);
        end
        apply("R4", 3, 16'hBEEF, 15, 0, 0, 0);
        apply("R4", 3, 16'hBEEF, 11, 8, 0, 0);
    endtask

    task automatic t_bit_ops();
        for (int b = 0; b <= W; b++) begin
            apply("R5", 4, 16'h5A3C, b, 0, b, 0);
            apply("R6", 5, 16'hFFFF, 0, 0, b, 0);
            apply("R6", 5, 16'h0000, 0, 0, b, 1);
            apply("R6", 5, 16'h1234, 0, 0, b, 9);
            apply("R6", 5, 16'h1234, 0, 0, b, 0);
        end
    endtask

    task automatic t_msb_lsb();
        apply("R7", 6, 16'h8000, 0, 0, 0, 0);
        apply("R7", 6, 16'h7FFF, 0, 0, 0, 0);
        apply("R7", 7, 16'h0001, 0, 0, 0, 0);
        apply("R7", 7, 16'hFFFE, 0, 0, 0, 0);
        apply("R11", 6, 16'h0000, 31, 31, 31, 0);
    endtask

    task automatic t_invalid();
        apply("R8", 0, 16'hFFFF, 31, 3, 0, 0);
        apply("R8", 3, 16'hFFFF, 20, 17, 0, 0);
        apply("R8", 1, 16'hFFFF, 4, 5, 0, 0);
        apply("R8", 4, 16'hFFFF, 0, 0, 31, 0);
        apply("R8", 5, 16'hFFFF, 0, 0, 24, 1);
        apply("R11", 2, 16'h0001, 0, 0, 0, 0);
    endtask

    task automatic t_enable_hold();
        apply("R9", 3, 16'hC0DE, 15, 4, 0, 0);
        en = 1'b0; op = 3'd6; word = 16'h0000; hi_idx = '0; lo_idx = '0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R9", 16'h0C0D, 1'b0, 1'b1);
        en = 1'b1;
        @(negedge clk);
        check("R9", 16'h0000, 1'b0, 1'b1);
    endtask

    task automatic t_reset_mid();
        apply("R10", 7, 16'h0001, 0, 0, 0, 0);
        rst = 1'b1;
        @(negedge clk);
        check("R10", '0, 1'b0, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        op = '0; word = '0; hi_idx = '0; lo_idx = '0; bit_idx = '0; set_val = '0;
        en = 1'b0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_reductions();
        t_extract();
        t_bit_ops();
        t_msb_lsb();
        t_invalid();
        t_enable_hold();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule